// File: doc/BRIEF.md
# Three-Wire Display Command/Data Receiver

This block is the serial front end of a display controller. A host drives three wires: an active-low enable, a serial clock and a serial data line. Each frame is nine bits long. The first bit is a kind flag. The other eight bits form a byte, sent most significant bit first. A frame whose flag is 0 gives a command byte. The block passes it on to the command decoder as a single-cycle strobe. A frame whose flag is 1 gives a display-data byte. The block writes it to display RAM through a single-cycle write port, at the address held in an internal counter. The counter then steps forward by one.

The three link wires are brought into the system clock domain through two-flop synchronizers. Serial clock edges are detected there, so the serial clock may run at no more than a quarter of the system clock rate. The host may hold the enable low across any number of frames and send them back to back. Raising the enable drops any partial frame. The address counter can be loaded by the command decoder through `set_addr`. Both output strobes are plain one-cycle pulses with no back-pressure, because the serial link cannot be stalled: the command decoder and the RAM must accept every pulse in the cycle it appears. An asynchronous active-low reset aborts any frame in progress and clears every register.

Top module: `disp_serial_rx`

## Requirements
- R1: While `rst_n` is low, and in the first cycles after it is released, `cmd_valid` and `ram_we` are 0 and `ram_addr` is 0.
- R2: While `link_en_n` is high, toggling of `link_clk` produces no `cmd_valid` or `ram_we` pulse and leaves `ram_addr` unchanged.
- R3: The first bit sampled on a rising `link_clk` edge after the enable falls is the kind flag. Flag 0 yields exactly one `cmd_valid` pulse. Flag 1 yields exactly one `ram_we` pulse.
- R4: The eight bits after the flag are sampled on rising `link_clk` edges and assembled with the first one as bit 7, so that bit 7 arrives first and bit 0 last. The result appears on `cmd_byte` or `ram_data`.
- R5: With the enable held low, the rising edge after the last byte bit is the flag of a new frame. Consecutive frames each produce their own strobe, in order.
- R6: `ram_addr` during a `ram_we` pulse is the current counter value. Afterwards the counter increases by one, wrapping from DEPTH-1 to 0. It changes at no other time except through R8 and R9.
- R7: A rising enable before the ninth bit of a frame discards that frame with no strobe. The next falling enable starts a new frame at the flag bit.
- R8: Asserting `rst_n` low in the middle of a frame discards it and clears `ram_addr` to 0. If the enable is low when reset is released, the next rising `link_clk` edge is taken as a flag.
- R9: A cycle with `set_addr` high loads `set_addr_value` into the counter. When it coincides with a `ram_we` increment, the load wins.
- R10: `cmd_valid` and `ram_we` are never high together, and neither is high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en_n | input | 1 | Serial link enable, active low |
| link_clk | input | 1 | Serial link clock; data taken on its rising edge |
| link_dat | input | 1 | Serial link data |
| set_addr | input | 1 | Load strobe for the address counter |
| set_addr_value | input | ADDR_W | Value loaded by `set_addr` |
| cmd_valid | output | 1 | One-cycle pulse: command byte received |
| cmd_byte | output | 8 | Received command byte, valid with `cmd_valid` |
| ram_we | output | 1 | One-cycle pulse: display-data byte to be written |
| ram_data | output | 8 | Display-data byte, valid with `ram_we` |
| ram_addr | output | ADDR_W | Current RAM address counter |

## Verification
Command bytes 0x80, 0x01, 0xA5, 0x00 and 0xFF are sent back to back under one enable. The mirror-image pair shows whether bit order is right, and the run as a whole shows whether frame boundaries stay aligned without gaps. Commands and data are interleaved, which separates the two strobes and shows that only data frames move the address. Partial frames cut off by a rising enable and by a reset, and clock bursts with the enable high, must leave no trace in the strobes or the counter. Address loads are tried on their own, held across a write to test priority, and at DEPTH-1 to reach the wrap.

// File: rtl/disp_serial_rx_pkg.sv
package disp_serial_rx_pkg;
  typedef enum logic {
    KIND_CMD  = 1'b0,
    KIND_DATA = 1'b1
  } frame_kind_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/dsr_sync.sv
// Two-flop synchronizer for a bundle of asynchronous level inputs.
module dsr_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= RST_VAL;
      q_sync <= RST_VAL;
    end else begin
      meta   <= d_async;
      q_sync <= meta;
    end
  end
endmodule

// File: rtl/dsr_frame.sv
// Frame assembler: flag bit followed by an MSB-first byte.
module dsr_frame
  import disp_serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              en_n_s,
  input  logic              dat_s,
  output logic              byte_valid,
  output frame_kind_e       byte_kind,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int          CW   = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W);

  logic              sclk_d;
  logic [CW-1:0]     cnt;
  frame_kind_e       kind_q;
  logic [BYTE_W-1:0] shreg;
  logic              rise;
  logic [BYTE_W-1:0] shnext;

  assign rise   = sclk_s & ~sclk_d;
  assign shnext = {shreg[BYTE_W-2:0], dat_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b0;
      cnt        <= '0;
      kind_q     <= KIND_CMD;
      shreg      <= '0;
      byte_valid <= 1'b0;
      byte_kind  <= KIND_CMD;
      byte_val   <= '0;
    end else begin
      sclk_d     <= sclk_s;
      byte_valid <= 1'b0;
      if (en_n_s) begin
        cnt   <= '0;
        shreg <= '0;
      end else if (rise) begin
        if (cnt == '0) begin
          kind_q <= frame_kind_e'(dat_s);
          cnt    <= CW'(1);
        end else begin
          shreg <= shnext;
          if (cnt == LAST) begin
            cnt        <= '0;
            byte_valid <= 1'b1;
            byte_kind  <= kind_q;
            byte_val   <= shnext;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/dsr_addr.sv
// Display RAM address counter with wrap and external load.
module dsr_addr #(
  parameter int DEPTH  = 864,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= load_val;
    else if (inc)     addr <= (addr == TOP) ? '0 : addr + ADDR_W'(1);
  end
endmodule

// File: rtl/disp_serial_rx.sv
module disp_serial_rx
  import disp_serial_rx_pkg::*;
#(
  parameter int DEPTH  = 864,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en_n,
  input  logic              link_clk,
  input  logic              link_dat,
  input  logic              set_addr,
  input  logic [ADDR_W-1:0] set_addr_value,
  output logic              cmd_valid,
  output logic [7:0]        cmd_byte,
  output logic              ram_we,
  output logic [7:0]        ram_data,
  output logic [ADDR_W-1:0] ram_addr
);
  logic [2:0]        sync_q;
  logic              byte_valid;
  frame_kind_e       byte_kind;
  logic [BYTE_W-1:0] byte_val;

  dsr_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({link_en_n, link_clk, link_dat}),
    .q_sync  (sync_q)
  );

  dsr_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_s     (sync_q[1]),
    .en_n_s     (sync_q[2]),
    .dat_s      (sync_q[0]),
    .byte_valid (byte_valid),
    .byte_kind  (byte_kind),
    .byte_val   (byte_val)
  );

  assign cmd_valid = byte_valid && (byte_kind == KIND_CMD);
  assign ram_we    = byte_valid && (byte_kind == KIND_DATA);
  assign cmd_byte  = byte_val;
  assign ram_data  = byte_val;

  dsr_addr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (ram_we),
    .load     (set_addr),
    .load_val (set_addr_value),
    .addr     (ram_addr)
  );
endmodule

// File: rtl/disp_serial_rx_chk.sv
module disp_serial_rx_chk #(
  parameter int DEPTH  = 864,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              set_addr,
  input logic [ADDR_W-1:0] set_addr_value,
  input logic              cmd_valid,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && ram_we));

  a_r10_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r10_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    set_addr |=> ram_addr == $past(set_addr_value));

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !set_addr) |=>
      ram_addr == (($past(ram_addr) == TOP) ? '0 : $past(ram_addr) + ADDR_W'(1)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we && !set_addr) |=> $stable(ram_addr));
endmodule

bind disp_serial_rx disp_serial_rx_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .set_addr       (set_addr),
  .set_addr_value (set_addr_value),
  .cmd_valid      (cmd_valid),
  .ram_we         (ram_we),
  .ram_addr       (ram_addr)
);

// File: tb/disp_serial_rx_tb.sv
module disp_serial_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 864;
  localparam int AW         = $clog2(DEPTH);
  localparam int HALF       = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          link_en_n = 1'b1;
  logic          link_clk = 1'b0;
  logic          link_dat = 1'b0;
  logic          set_addr = 1'b0;
  logic [AW-1:0] set_addr_value = '0;
  logic          cmd_valid, ram_we;
  logic [7:0]    cmd_byte, ram_data;
  logic [AW-1:0] ram_addr;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [7:0]        cmd_q[$];
  logic [8+AW-1:0]   wr_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_serial_rx #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_en_n(link_en_n), .link_clk(link_clk),
    .link_dat(link_dat), .set_addr(set_addr), .set_addr_value(set_addr_value),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .ram_we(ram_we),
    .ram_data(ram_data), .ram_addr(ram_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [8:0] bits, input int n);
    for (int i = 8; i > 8 - n; i--) begin
      link_dat = bits[i];
      wait_clk(HALF);
      link_clk = 1'b1;
      wait_clk(HALF);
      link_clk = 1'b0;
    end
  endtask

  task automatic send_frame(input logic kind, input logic [7:0] b);
    if (kind) begin
      wr_q.push_back({b, exp_addr});
      exp_addr = (exp_addr == AW'(DEPTH - 1)) ? '0 : exp_addr + AW'(1);
    end else begin
      cmd_q.push_back(b);
    end
    send_bits({kind, b}, 9);
  endtask

  task automatic en_low();
    wait_clk(HALF);
    link_en_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic en_high();
    wait_clk(HALF);
    link_en_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic drain(input string req);
    wait_clk(12);
    check(cmd_q.size() == 0 && wr_q.size() == 0, req,
          cmd_q.size() + wr_q.size(), 0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin
        pulses++;
        if (cmd_q.size() == 0) check(1'b0, "R3 unexpected cmd_valid", cmd_byte, -1);
        else begin
          logic [7:0] e;
          e = cmd_q.pop_front();
          check(cmd_byte == e, "R4 cmd_byte", cmd_byte, e);
        end
      end
      if (ram_we) begin
        pulses++;
        if (wr_q.size() == 0) check(1'b0, "R3 unexpected ram_we", ram_data, -1);
        else begin
          logic [8+AW-1:0] e;
          e = wr_q.pop_front();
          check(ram_data == e[8+AW-1:AW], "R4 ram_data", ram_data, e[8+AW-1:AW]);
          check(ram_addr == e[AW-1:0], "R6 ram_addr at write", ram_addr, e[AW-1:0]);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    // R1 reset state
    wait_clk(3);
    check(!cmd_valid && !ram_we, "R1 strobes in reset", {cmd_valid, ram_we}, 0);
    check(ram_addr == 0, "R1 addr in reset", ram_addr, 0);
    rst_n = 1'b1;
    wait_clk(3);
    check(!cmd_valid && !ram_we && ram_addr == 0, "R1 after release", ram_addr, 0);

    // R2 clocks with enable high
    p0 = pulses;
    send_bits(9'h1FF, 9);
    send_bits(9'h0A5, 9);
    wait_clk(10);
    check(pulses == p0, "R2 no strobe with enable high", pulses - p0, 0);
    check(ram_addr == 0, "R2 addr unchanged", ram_addr, 0);

    // R3 R4 R5 back-to-back commands, mirror bit patterns
    en_low();
    send_frame(1'b0, 8'h80);
    send_frame(1'b0, 8'h01);
    send_frame(1'b0, 8'hA5);
    send_frame(1'b0, 8'h00);
    send_frame(1'b0, 8'hFF);
    en_high();
    drain("R5 back-to-back commands drained");

    // R3 R6 interleaved data and commands
    en_low();
    send_frame(1'b1, 8'h11);
    send_frame(1'b0, 8'h2C);
    send_frame(1'b1, 8'h22);
    send_frame(1'b1, 8'hC3);
    en_high();
    drain("R6 interleaved drained");
    check(ram_addr == 3, "R6 addr after three writes", ram_addr, 3);

    // R7 rising enable mid-frame discards
    p0 = pulses;
    en_low();
    send_bits(9'h1F0, 5);
    en_high();
    wait_clk(10);
    check(pulses == p0, "R7 partial frame no strobe", pulses - p0, 0);
    check(ram_addr == 3, "R7 addr unchanged", ram_addr, 3);
    en_low();
    send_frame(1'b0, 8'h5A);
    send_frame(1'b1, 8'h77);
    en_high();
    drain("R7 fresh frame after abort");

    // R8 reset mid-frame, enable stays low afterwards
    en_low();
    send_bits(9'h1AA, 6);
    wait_clk(2);
    rst_n = 1'b0;
    wait_clk(3);
    check(ram_addr == 0, "R8 addr cleared", ram_addr, 0);
    rst_n = 1'b1;
    exp_addr = '0;
    wait_clk(4);
    send_frame(1'b1, 8'h9E);
    send_frame(1'b0, 8'h3D);
    en_high();
    drain("R8 frames after reset");
    check(ram_addr == 1, "R8 addr after one write", ram_addr, 1);

    // R9 plain load
    set_addr_value = AW'(500);
    set_addr = 1'b1;
    wait_clk(1);
    set_addr = 1'b0;
    exp_addr = AW'(500);
    wait_clk(2);
    check(ram_addr == 500, "R9 load", ram_addr, 500);
    en_low();
    send_frame(1'b1, 8'h44);
    en_high();
    drain("R9 write at loaded address");

    // R9 load held across a write: load wins over increment
    set_addr_value = AW'(300);
    set_addr = 1'b1;
    exp_addr = AW'(300);
    en_low();
    wr_q.push_back({8'h3C, AW'(300)});
    send_bits({1'b1, 8'h3C}, 9);
    en_high();
    drain("R9 write during load");
    check(ram_addr == 300, "R9 load wins over increment", ram_addr, 300);
    set_addr = 1'b0;
    wait_clk(2);
    en_low();
    send_frame(1'b1, 8'h01);
    en_high();
    drain("R9 write after held load");
    check(ram_addr == 301, "R9 increment resumes", ram_addr, 301);

    // R6 wrap at DEPTH-1
    set_addr_value = AW'(DEPTH - 1);
    set_addr = 1'b1;
    wait_clk(1);
    set_addr = 1'b0;
    exp_addr = AW'(DEPTH - 1);
    en_low();
    send_frame(1'b1, 8'hE1);
    send_frame(1'b1, 8'hE2);
    en_high();
    drain("R6 wrap writes");
    check(ram_addr == 1, "R6 addr after wrap", ram_addr, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule